// File: doc/BRIEF.md
# Grouped Pin Interrupt Controller

This block collects interrupt requests from up to four groups of eight input pins onto one 32-bit interrupt channel. The channel has four byte-wide lanes. Each lane takes one whole group of eight pins, and software chooses which group. Every channel bit can be set to level-sensitive or edge-sensitive operation, and each bit has its own polarity. A per-bit latch records each request. The latch, the interrupt mask, and the raw synchronized pin values can be read at any time, whether or not the bit is masked. A single registered request line leaves the block.

Software uses a simple single-cycle register bus with word addresses. Each configuration register and the latch has a pair of addresses: writing ones to the first address sets those bits, and writing ones to the second address clears them. A single bit can therefore change without a read-modify-write. The pin inputs pass through a synchronizer chain inside the block, so they may change at any time.

Top module: `pint_channel`

## Requirements
- R1: After reset, every readable address returns zero and `irq_o` is low.
- R2: Writing to address 0 sets the mask bits that are one in the write data. Writing to address 1 clears the mask bits that are one. All other mask bits keep their value. A read at address 0 or at address 1 returns the mask.
- R3: Addresses 6 and 7 set and clear the lane assignment register. Channel lane k (channel bits 8k+7..8k) takes half-port j (`pins_i[8j+7:8j]`), where j is the value in assignment bits 2k+1..2k. Only bits 7..0 of this register can be set.
- R4: A read at address 10 returns the synchronized pin value of every channel bit, taken from the half-port assigned to its lane. Mask, sense mode and polarity do not change this value.
- R5: A channel bit is in level mode when its sense bit is 0 (set at address 2, cleared at address 3). In level mode the latch bit (read at address 8) follows the pin value XOR the polarity bit (set at address 4, cleared at address 5).
- R6: A channel bit is in edge mode when its sense bit is 1. In edge mode the latch bit is set by a rising pin edge when the polarity bit is 0, or by a falling pin edge when the polarity bit is 1. The latch bit then stays set until a one is written to that bit at address 9.
- R7: Writing ones to address 8 sets edge-mode latch bits as a software request. Writes to address 8 or address 9 have no effect on level-mode latch bits.
- R8: A read at address 11 returns the latch AND the mask. A read at address 8 returns the latch whether or not the bits are masked.
- R9: `irq_o` is high in the cycle after the latch AND the mask is non-zero, and low in the cycle after it is zero.
- R10: When an edge is detected on an edge-mode bit in the same cycle that a clear of that bit is written at address 9, the latch bit is set.
- R11: With the default two synchronizer stages, a pin change first sampled at clock edge n appears in the latch at edge n+2 and on `irq_o` at edge n+3.
- R12: An assignment code that names a half-port that does not exist (code 3 with three half-ports) gives all-zero pin values for that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_HP*8 | Pin inputs, eight per half-port |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A hardware edge that sets a latch bit and a software clear of that same bit can fall in the same cycle. The bench provokes this by counting the synchronizer stages from the pin change. It then places the clear write on the exact clock edge where the detected edge reaches the latch. The check passes when the latch bit reads back as set after that edge. A later clear with no edge present must then empty the bit, which shows that the write itself worked. The vector table also covers a second overlap: level-mode and edge-mode bits of one channel updating in the same cycle.

// File: rtl/pint_pkg.sv
package pint_pkg;
   localparam int LANE_W = 8;
   localparam int LANES  = 4;
   localparam int CH_W   = LANE_W * LANES;
   localparam int SEL_W  = 2;
   localparam int ASG_W  = SEL_W * LANES;
   localparam int ADDR_W = 4;
   localparam int CFG_N  = 4;

   // index of each set/clear configuration word; its set address is 2*index
   localparam int CFG_MSK = 0;
   localparam int CFG_EDG = 1;
   localparam int CFG_POL = 2;
   localparam int CFG_ASG = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_MSK_S = 4'd0,
      A_MSK_C = 4'd1,
      A_EDG_S = 4'd2,
      A_EDG_C = 4'd3,
      A_POL_S = 4'd4,
      A_POL_C = 4'd5,
      A_ASG_S = 4'd6,
      A_ASG_C = 4'd7,
      A_LAT_S = 4'd8,
      A_LAT_C = 4'd9,
      A_PIN   = 4'd10,
      A_REQ   = 4'd11
   } pint_addr_e;
endpackage

// File: rtl/pint_sync.sv
module pint_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pint_regs.sv
module pint_regs
   import pint_pkg::*;
#(
   parameter int AW = ADDR_W,
   parameter int DW = CH_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [AW-1:0]            addr,
   input  logic [DW-1:0]            wdata,
   output logic [CFG_N-1:0][DW-1:0] cfg
);
   for (genvar g = 0; g < CFG_N; g++) begin : g_word
      localparam logic [DW-1:0] KEEP =
         (g == CFG_ASG) ? DW'((64'd1 << ASG_W) - 64'd1) : {DW{1'b1}};
      logic          set_hit, clr_hit;
      logic [DW-1:0] q;

      assign set_hit = we && (addr == AW'(2 * g));
      assign clr_hit = we && (addr == AW'(2 * g + 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       q <= '0;
         else if (set_hit) q <= (q | wdata) & KEEP;
         else if (clr_hit) q <= q & ~wdata;
      end

      assign cfg[g] = q;
   end
endmodule

// File: rtl/pint_lane_mux.sv
module pint_lane_mux
   import pint_pkg::*;
#(
   parameter int NUM_HP = 3
) (
   input  logic [NUM_HP*LANE_W-1:0] pins,
   input  logic [ASG_W-1:0]         asg,
   output logic [CH_W-1:0]          raw
);
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [SEL_W-1:0]  sel;
      logic [LANE_W-1:0] lane_val;

      assign sel = asg[k*SEL_W +: SEL_W];

      always_comb begin
         lane_val = '0;
         for (int j = 0; j < NUM_HP; j++) begin
            if (sel == SEL_W'(j)) lane_val = pins[j*LANE_W +: LANE_W];
         end
      end

      assign raw[k*LANE_W +: LANE_W] = lane_val;
   end
endmodule

// File: rtl/pint_latch.sv
module pint_latch #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw,
   input  logic [W-1:0] edg,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] sw_set,
   input  logic [W-1:0] sw_clr,
   output logic [W-1:0] latch_q,
   output logic [W-1:0] act
);
   assign act = raw ^ pol;

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic prev_q, lq, hit;

      // edge is judged on the raw pin so a polarity change cannot fake one
      assign hit = pol[b] ? (prev_q & ~raw[b]) : (raw[b] & ~prev_q);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            lq     <= 1'b0;
         end else begin
            prev_q <= raw[b];
            if (edg[b]) lq <= hit | sw_set[b] | (lq & ~sw_clr[b]);
            else        lq <= act[b];
         end
      end

      assign latch_q[b] = lq;
   end
endmodule

// File: rtl/pint_channel.sv
module pint_channel
   import pint_pkg::*;
#(
   parameter int NUM_HP      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_HP*LANE_W-1:0] pins_i,
   input  logic                     bus_we,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [CH_W-1:0]          bus_wdata,
   output logic [CH_W-1:0]          bus_rdata,
   output logic                     irq_o
);
   localparam int PIN_W = NUM_HP * LANE_W;

   if (NUM_HP < 1 || NUM_HP > (1 << SEL_W)) begin : g_bad_hp
      $error("pint_channel: NUM_HP must lie between 1 and %0d", 1 << SEL_W);
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pint_channel: SYNC_STAGES must be at least 2");
   end

   logic [PIN_W-1:0]           pins_s;
   logic [CFG_N-1:0][CH_W-1:0] cfg;
   logic [CH_W-1:0]            msk_w, edg_w, pol_w;
   logic [ASG_W-1:0]           asg_w;
   logic [CH_W-1:0]            raw_w, lat_w, act_w;
   logic [CH_W-1:0]            lat_set, lat_clr;
   logic                       irq_q;

   pint_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_i),
      .q     (pins_s)
   );

   pint_regs #(.AW(ADDR_W), .DW(CH_W)) i_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bus_we),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .cfg   (cfg)
   );

   assign msk_w = cfg[CFG_MSK];
   assign edg_w = cfg[CFG_EDG];
   assign pol_w = cfg[CFG_POL];
   assign asg_w = cfg[CFG_ASG][ASG_W-1:0];

   pint_lane_mux #(.NUM_HP(NUM_HP)) i_mux (
      .pins (pins_s),
      .asg  (asg_w),
      .raw  (raw_w)
   );

   assign lat_set = (bus_we && bus_addr == A_LAT_S) ? bus_wdata : '0;
   assign lat_clr = (bus_we && bus_addr == A_LAT_C) ? bus_wdata : '0;

   pint_latch #(.W(CH_W)) i_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw     (raw_w),
      .edg     (edg_w),
      .pol     (pol_w),
      .sw_set  (lat_set),
      .sw_clr  (lat_clr),
      .latch_q (lat_w),
      .act     (act_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(lat_w & msk_w);
   end
   assign irq_o = irq_q;

   always_comb begin
      unique case (bus_addr)
         A_MSK_S, A_MSK_C: bus_rdata = msk_w;
         A_EDG_S, A_EDG_C: bus_rdata = edg_w;
         A_POL_S, A_POL_C: bus_rdata = pol_w;
         A_ASG_S, A_ASG_C: bus_rdata = cfg[CFG_ASG];
         A_LAT_S, A_LAT_C: bus_rdata = lat_w;
         A_PIN:            bus_rdata = raw_w;
         A_REQ:            bus_rdata = lat_w & msk_w;
         default:          bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pint_channel_chk.sv
module pint_channel_chk
   import pint_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [CH_W-1:0]   bus_wdata,
   input logic              irq_o,
   input logic [CH_W-1:0]   msk_w,
   input logic [CH_W-1:0]   edg_w,
   input logic [CH_W-1:0]   lat_w,
   input logic [CH_W-1:0]   act_w
);
   logic msk_set_wr, msk_clr_wr;
   assign msk_set_wr = bus_we && (bus_addr == A_MSK_S);
   assign msk_clr_wr = bus_we && (bus_addr == A_MSK_C);

   assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      msk_set_wr |=> ((msk_w & $past(bus_wdata)) == $past(bus_wdata)));

   assert_mask_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      msk_clr_wr |=> ((msk_w & $past(bus_wdata)) == '0));

   assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(msk_set_wr || msk_clr_wr) |=> $stable(msk_w));

   assert_level_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((lat_w & ~$past(edg_w)) == ($past(act_w) & ~$past(edg_w))));

   assert_edge_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> (($past(lat_w & edg_w) & ~lat_w) == '0));

   assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((lat_w & msk_w) != '0) |=> irq_o);

   assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((lat_w & msk_w) == '0) |=> !irq_o);
endmodule

bind pint_channel pint_channel_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq_o     (irq_o),
   .msk_w     (msk_w),
   .edg_w     (edg_w),
   .lat_w     (lat_w),
   .act_w     (act_w)
);

// File: tb/test_pint_channel.sv
module test_pint_channel;
   localparam int NHP = 3;
   localparam int PW  = NHP * 8;

   localparam logic [3:0] MSK_S = 4'd0, MSK_C = 4'd1, EDG_S = 4'd2, EDG_C = 4'd3;
   localparam logic [3:0] POL_S = 4'd4, POL_C = 4'd5, ASG_S = 4'd6, ASG_C = 4'd7;
   localparam logic [3:0] LAT_S = 4'd8, LAT_C = 4'd9, PINR  = 4'd10, REQR = 4'd11;

   typedef struct packed {
      logic [7:0]  asg;
      logic [31:0] edg;
      logic [31:0] pol;
      logic [31:0] msk;
      logic [23:0] pa;
      logic [23:0] pb;
      logic [31:0] lat;
      logic        irq;
   } row_t;

   localparam int NROW = 6;
   localparam row_t TBL [NROW] = '{
      '{8'hE4, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 24'h000000, 24'hC35A81, 32'h00C3_5A81, 1'b1},
      '{8'h02, 32'h0000_0000, 32'hFFFF_0000, 32'h0000_0000, 24'h000000, 24'h0F00A5, 32'h5A5A_A50F, 1'b0},
      '{8'hE4, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_00FF, 24'h000000, 24'h00003C, 32'h0000_003C, 1'b1},
      '{8'hE4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_FF00, 24'h00F000, 24'h003000, 32'h0000_C000, 1'b1},
      '{8'hE4, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 24'hFF0000, 24'h0F0000, 32'h0000_0000, 1'b0},
      '{8'hE4, 32'h0000_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 24'h000000, 24'h112233, 32'h0011_2233, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic [PW-1:0] pins;
   logic          bus_we;
   logic [3:0]    bus_addr;
   logic [31:0]   bus_wdata;
   logic [31:0]   bus_rdata;
   logic          irq_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   pint_channel #(.NUM_HP(NHP)) i_pint_channel (
      .clk       (clk),
      .rst_n     (rst_n),
      .pins_i    (pins),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic clear_all();
      @(negedge clk); pins = '0;
      wr(MSK_C, '1); wr(EDG_C, '1); wr(POL_C, '1); wr(ASG_C, '1);
      idle(4);
      wr(LAT_C, '1);
   endtask

   function automatic logic [31:0] pin_view(input logic [7:0] asg, input logic [23:0] p);
      logic [31:0] v = '0;
      for (int k = 0; k < 4; k++) begin
         int s = int'(asg[2*k +: 2]);
         if (s < NHP) v[8*k +: 8] = p[8*s +: 8];
      end
      return v;
   endfunction

   initial begin : watchdog
      idle(200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      rst_n = 1'b0; pins = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
      idle(3);
      @(negedge clk); rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 12; a++) begin
         rd(4'(a), d);
         chk("R1 reset read", d, 32'h0);
      end
      chk("R1 reset irq", {31'b0, irq_o}, 32'h0);

      // R2: mask set/clear touches only written bits
      wr(MSK_S, 32'hF0F0_0000);
      wr(MSK_S, 32'h0000_000F);
      wr(MSK_C, 32'h1000_0001);
      rd(MSK_S, d); chk("R2 mask at set address", d, 32'hE0F0_000E);
      rd(MSK_C, d); chk("R2 mask at clear address", d, 32'hE0F0_000E);

      // R3: only the eight assignment bits can be set
      wr(ASG_S, 32'hFFFF_FF39);
      rd(ASG_C, d); chk("R3 assign width", d, 32'h0000_0039);
      clear_all();

      // table walk: R3 R4 R5 R6 R8 R9 R12
      for (int r = 0; r < NROW; r++) begin
         clear_all();
         wr(ASG_S, {24'h0, TBL[r].asg});
         wr(EDG_S, TBL[r].edg);
         wr(POL_S, TBL[r].pol);
         @(negedge clk); pins = TBL[r].pa;
         idle(5);
         wr(LAT_C, '1);
         wr(MSK_S, TBL[r].msk);
         @(negedge clk); pins = TBL[r].pb;
         idle(5);
         rd(LAT_S, d); chk("R5 R6 R12 latch row", d, TBL[r].lat);
         rd(REQR, d);  chk("R8 request row", d, TBL[r].lat & TBL[r].msk);
         rd(PINR, d);  chk("R4 R3 pin view row", d, pin_view(TBL[r].asg, TBL[r].pb));
         chk("R9 irq row", {31'b0, irq_o}, {31'b0, TBL[r].irq});
      end

      // R7: software set and clear act on edge-mode bits only
      clear_all();
      wr(EDG_S, 32'h8000_0001);
      wr(LAT_S, 32'h8000_0003);
      rd(LAT_S, d); chk("R7 software set edge bits", d, 32'h8000_0001);
      wr(LAT_C, 32'h0000_0001);
      rd(LAT_S, d); chk("R7 software clear edge bit", d, 32'h8000_0000);
      wr(ASG_S, 32'h0000_00E4);
      @(negedge clk); pins = 24'h000002;
      idle(5);
      wr(LAT_C, 32'h0000_0002);
      rd(LAT_S, d); chk("R7 level bit ignores clear", d, 32'h8000_0002);

      // R11: latency from pin to latch and to irq
      clear_all();
      wr(ASG_S, 32'h0000_00E4); wr(EDG_S, 32'h0000_0001); wr(MSK_S, 32'h0000_0001);
      idle(4);
      wr(LAT_C, '1);
      @(negedge clk); pins = 24'h000001;
      @(posedge clk); @(posedge clk);
      rd(LAT_S, d); chk("R11 latch before third edge", d, 32'h0);
      rd(LAT_S, d); chk("R11 latch after third edge", d, 32'h1);
      chk("R11 irq not yet", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      chk("R11 irq after fourth edge", {31'b0, irq_o}, 32'h1);

      // R10: edge detection and clear write land on the same edge
      clear_all();
      wr(ASG_S, 32'h0000_00E4); wr(EDG_S, 32'h0000_0001);
      idle(4);
      wr(LAT_C, '1);
      @(negedge clk); pins = 24'h000001;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = LAT_C; bus_wdata = 32'h1;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
      rd(LAT_S, d); chk("R10 edge wins over clear", d, 32'h1);
      wr(LAT_C, 32'h1);
      rd(LAT_S, d); chk("R10 later clear empties bit", d, 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule